// File: doc/BRIEF.md
# Missed-Word-Early Cache Line Refill Engine

This block sits between a cache controller and a slower word-wide memory port. When the cache misses, the controller hands the engine a line address, the word offset the processor is waiting for, and a fill-order choice. The engine requests every word of the line from memory, one request per word. It writes each returned word into the data array. As soon as the word the processor asked for comes back, the engine returns that word to the processor, without waiting for the rest of the line.

Two fill orders are offered. In wrap order, the missed word is requested first and the following offsets come after it, wrapping past the end of the line back to zero. In linear order, the offsets are requested from zero upward, and the processor is released when the missed word appears in that stream. In both orders the remaining words keep arriving after the processor is released. The engine signals completion with a single-cycle strobe, which the cache uses to set the line valid. Only one fill runs at a time.

Top module: `line_refill_engine`

## Requirements
- R1: After reset, miss_ready is 1, and mem_req_valid, arr_wr_en, cpu_rsp_valid and fill_done are all 0.
- R2: With miss_order = 0 (wrap order) and missed offset k, the i-th accepted memory request carries offset (k + i) mod WORDS, so the first request is for the missed word.
- R3: With miss_order = 1 (linear order), the i-th accepted memory request carries offset i, whatever the missed offset is.
- R4: Each accepted miss produces exactly WORDS accepted memory requests. Each request carries the captured line address. The miss_order, offset and line address are sampled only at acceptance.
- R5: A memory response accepted at a clock edge appears on the array write port after that same edge. It carries the offset of its matching request (responses return in request order), the unchanged data and the line address.
- R6: cpu_rsp_valid pulses exactly once per fill, after the edge that accepts the response for the missed offset, and carries that response's data.
- R7: After the processor is released, the rest of the line is still written. The number of array writes that follow the release equals WORDS − 1 − (position of the missed word in the request order).
- R8: fill_done is a one-cycle pulse. It is raised together with the array write that completes the line, and only once per fill.
- R9: miss_ready stays 0 from the accepting edge until the last word is written. A miss offered during that time is neither accepted nor able to alter the running fill. miss_ready is 1 again in the cycle fill_done is high.
- R10: While mem_req_valid is 1 and mem_req_ready is 0, the request stays valid with an unchanged offset and line address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | A miss is offered |
| miss_ready | output | 1 | Engine idle, a miss is accepted this cycle |
| miss_line_addr | input | LINE_AW | Line address of the miss |
| miss_word_ofs | input | OFS_W | Word offset the processor waits for |
| miss_order | input | 1 | 0 = wrap order from missed word, 1 = linear order from word 0 |
| mem_req_valid | output | 1 | Word request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line_addr | output | LINE_AW | Line address of the request |
| mem_req_word_ofs | output | OFS_W | Word offset of the request |
| mem_rsp_valid | input | 1 | One response word, in request order |
| mem_rsp_data | input | WORD_W | Response data |
| cpu_rsp_valid | output | 1 | Missed word returned to the processor |
| cpu_rsp_data | output | WORD_W | Missed word data |
| arr_wr_en | output | 1 | Data-array word write |
| arr_wr_line_addr | output | LINE_AW | Line being written |
| arr_wr_word_ofs | output | OFS_W | Word offset written |
| arr_wr_data | output | WORD_W | Word written |
| fill_done | output | 1 | Line complete, may be marked valid |

## Verification
The hardest situations to reach are the ones where request stalls, response latency and the missed word's place in the stream coincide. Examples are a missed word that is the last one of a linear fill, so release and completion happen together, and a request stalled at the moment earlier responses are still returning. The bench sweeps every missed offset under both orders. It varies the memory's acceptance pattern and response latency per sweep point, so stalls fall at different request indices. During some fills it also holds a conflicting miss on the input, with the order bit flipped, and withdraws it exactly when completion is seen.

// File: rtl/lre_pkg.sv
package lre_pkg;
   typedef enum logic {
      ORDER_WRAP   = 1'b0,
      ORDER_LINEAR = 1'b1
   } fill_order_e;
endpackage

// File: rtl/lre_order_gen.sv
module lre_order_gen
   import lre_pkg::*;
#(
   parameter int WORDS = 8,
   localparam int OFS_W = $clog2(WORDS)
) (
   input  logic [OFS_W-1:0] crit_ofs,
   input  fill_order_e      order,
   input  logic [OFS_W-1:0] seq_idx,
   output logic [OFS_W-1:0] word_ofs
);
   logic [OFS_W-1:0] wrap_ofs;

   generate
      if (WORDS == (1 << OFS_W)) begin : g_pow2
         // modulo by natural overflow of the offset field
         assign wrap_ofs = crit_ofs + seq_idx;
      end else begin : g_generic
         logic [OFS_W:0] sum;
         assign sum      = {1'b0, crit_ofs} + {1'b0, seq_idx};
         assign wrap_ofs = (sum >= (OFS_W+1)'(WORDS)) ? OFS_W'(sum - (OFS_W+1)'(WORDS))
                                                      : OFS_W'(sum);
      end
   endgenerate

   assign word_ofs = (order == ORDER_LINEAR) ? seq_idx : wrap_ofs;
endmodule

// File: rtl/lre_req_issuer.sv
module lre_req_issuer #(
   parameter int WORDS = 8,
   localparam int OFS_W = $clog2(WORDS),
   localparam int CNT_W = OFS_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             req_ready,
   output logic             req_active,
   output logic [OFS_W-1:0] req_idx,
   output logic [CNT_W-1:0] issued_cnt
);
   localparam logic [CNT_W-1:0] ALL_SENT = CNT_W'(WORDS);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ALL_SENT;
      end else if (start) begin
         cnt_q <= '0;
      end else if (req_active && req_ready) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign req_active = (cnt_q != ALL_SENT);
   assign req_idx    = cnt_q[OFS_W-1:0];
   assign issued_cnt = cnt_q;

   // R10: a stalled request is held steady
   a_r10_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (req_active && !req_ready && !start) |=> (req_active && $stable(req_idx)));
endmodule

// File: rtl/lre_rsp_tracker.sv
module lre_rsp_tracker #(
   parameter int WORDS  = 8,
   parameter int WORD_W = 32,
   localparam int OFS_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_data,
   input  logic [OFS_W-1:0]  rsp_ofs,
   input  logic [OFS_W-1:0]  crit_ofs,
   output logic [OFS_W-1:0]  rsp_idx,
   output logic              rsp_last,
   output logic              wr_en,
   output logic [OFS_W-1:0]  wr_ofs,
   output logic [WORD_W-1:0] wr_data,
   output logic              cpu_valid,
   output logic [WORD_W-1:0] cpu_data,
   output logic              done
);
   logic [OFS_W-1:0] idx_q;
   logic [WORDS-1:0] filled_q;
   logic [WORDS-1:0] filled_nxt;
   logic [WORDS-1:0] hit_vec;

   // one presence bit per word of the line
   genvar gi;
   generate
      for (gi = 0; gi < WORDS; gi++) begin : g_word
         assign hit_vec[gi]    = rsp_valid && (rsp_ofs == OFS_W'(gi));
         assign filled_nxt[gi] = filled_q[gi] | hit_vec[gi];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         filled_q <= '0;
      end else if (start) begin
         idx_q    <= '0;
         filled_q <= '0;
      end else if (rsp_valid) begin
         idx_q    <= idx_q + 1'b1;
         filled_q <= filled_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en     <= 1'b0;
         wr_ofs    <= '0;
         wr_data   <= '0;
         cpu_valid <= 1'b0;
         cpu_data  <= '0;
         done      <= 1'b0;
      end else begin
         wr_en     <= rsp_valid;
         cpu_valid <= rsp_valid && (rsp_ofs == crit_ofs);
         done      <= rsp_valid && (&filled_nxt) && !(&filled_q);
         if (rsp_valid) begin
            wr_ofs  <= rsp_ofs;
            wr_data <= rsp_data;
         end
         if (rsp_valid && (rsp_ofs == crit_ofs)) begin
            cpu_data <= rsp_data;
         end
      end
   end

   assign rsp_idx  = idx_q;
   assign rsp_last = rsp_valid && (idx_q == OFS_W'(WORDS - 1));

   // R8: completion strobe rides on a write and lasts one cycle
   a_r8_done_with_write : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> wr_en);
   a_r8_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: processor return is a single-cycle pulse
   a_r6_cpu_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |=> !cpu_valid);
endmodule

// File: rtl/line_refill_engine.sv
module line_refill_engine
   import lre_pkg::*;
#(
   parameter int WORDS   = 8,
   parameter int WORD_W  = 32,
   parameter int LINE_AW = 26,
   localparam int OFS_W  = $clog2(WORDS),
   localparam int CNT_W  = OFS_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               miss_valid,
   output logic               miss_ready,
   input  logic [LINE_AW-1:0] miss_line_addr,
   input  logic [OFS_W-1:0]   miss_word_ofs,
   input  logic               miss_order,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [LINE_AW-1:0] mem_req_line_addr,
   output logic [OFS_W-1:0]   mem_req_word_ofs,
   input  logic               mem_rsp_valid,
   input  logic [WORD_W-1:0]  mem_rsp_data,
   output logic               cpu_rsp_valid,
   output logic [WORD_W-1:0]  cpu_rsp_data,
   output logic               arr_wr_en,
   output logic [LINE_AW-1:0] arr_wr_line_addr,
   output logic [OFS_W-1:0]   arr_wr_word_ofs,
   output logic [WORD_W-1:0]  arr_wr_data,
   output logic               fill_done
);
   generate
      if (WORDS < 2 || WORDS != (1 << OFS_W)) begin : g_bad_words
         $error("line_refill_engine: WORDS must be a power of two, at least 2");
      end
      if (WORD_W < 1 || LINE_AW < 1) begin : g_bad_width
         $error("line_refill_engine: widths must be positive");
      end
   endgenerate

   logic               busy_q;
   logic [LINE_AW-1:0] line_q;
   logic [OFS_W-1:0]   crit_q;
   fill_order_e        order_q;
   logic               accept;
   logic               rsp_last;
   logic [OFS_W-1:0]   req_idx;
   logic [OFS_W-1:0]   rsp_idx;
   logic [OFS_W-1:0]   rsp_ofs;
   logic [CNT_W-1:0]   issued_cnt;

   assign miss_ready = !busy_q;
   assign accept     = miss_valid && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         line_q  <= '0;
         crit_q  <= '0;
         order_q <= ORDER_WRAP;
      end else if (accept) begin
         busy_q  <= 1'b1;
         line_q  <= miss_line_addr;
         crit_q  <= miss_word_ofs;
         order_q <= fill_order_e'(miss_order);
      end else if (rsp_last) begin
         busy_q  <= 1'b0;
      end
   end

   lre_req_issuer #(.WORDS(WORDS)) u_issuer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .req_ready  (mem_req_ready),
      .req_active (mem_req_valid),
      .req_idx    (req_idx),
      .issued_cnt (issued_cnt)
   );

   lre_order_gen #(.WORDS(WORDS)) u_req_order (
      .crit_ofs (crit_q),
      .order    (order_q),
      .seq_idx  (req_idx),
      .word_ofs (mem_req_word_ofs)
   );

   lre_order_gen #(.WORDS(WORDS)) u_rsp_order (
      .crit_ofs (crit_q),
      .order    (order_q),
      .seq_idx  (rsp_idx),
      .word_ofs (rsp_ofs)
   );

   lre_rsp_tracker #(.WORDS(WORDS), .WORD_W(WORD_W)) u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .rsp_valid (mem_rsp_valid),
      .rsp_data  (mem_rsp_data),
      .rsp_ofs   (rsp_ofs),
      .crit_ofs  (crit_q),
      .rsp_idx   (rsp_idx),
      .rsp_last  (rsp_last),
      .wr_en     (arr_wr_en),
      .wr_ofs    (arr_wr_word_ofs),
      .wr_data   (arr_wr_data),
      .cpu_valid (cpu_rsp_valid),
      .cpu_data  (cpu_rsp_data),
      .done      (fill_done)
   );

   assign mem_req_line_addr = line_q;
   assign arr_wr_line_addr  = line_q;

   // R9: no new miss while requests of the current fill are pending
   a_r9_busy_while_req : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !miss_ready);
   // R9: engine idle again by the time the completion strobe is visible
   a_r9_ready_at_done : assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> miss_ready);
   // R4: responses never outrun accepted requests
   a_r4_rsp_behind_req : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && mem_rsp_valid) |-> ({1'b0, rsp_idx} < issued_cnt));
   // R4: line address frozen during a fill
   a_r4_line_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !rsp_last) |=> $stable(mem_req_line_addr));
endmodule

// File: tb/tb_line_refill_engine.sv
module tb_line_refill_engine;
   localparam int WORDS   = 8;
   localparam int WORD_W  = 32;
   localparam int LINE_AW = 26;
   localparam int OFS_W   = $clog2(WORDS);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               miss_valid = 1'b0;
   logic               miss_ready;
   logic [LINE_AW-1:0] miss_line_addr = '0;
   logic [OFS_W-1:0]   miss_word_ofs = '0;
   logic               miss_order = 1'b0;
   logic               mem_req_valid;
   logic               mem_req_ready = 1'b0;
   logic [LINE_AW-1:0] mem_req_line_addr;
   logic [OFS_W-1:0]   mem_req_word_ofs;
   logic               mem_rsp_valid = 1'b0;
   logic [WORD_W-1:0]  mem_rsp_data = '0;
   logic               cpu_rsp_valid;
   logic [WORD_W-1:0]  cpu_rsp_data;
   logic               arr_wr_en;
   logic [LINE_AW-1:0] arr_wr_line_addr;
   logic [OFS_W-1:0]   arr_wr_word_ofs;
   logic [WORD_W-1:0]  arr_wr_data;
   logic               fill_done;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   line_refill_engine #(.WORDS(WORDS), .WORD_W(WORD_W), .LINE_AW(LINE_AW)) dut (.*);

   function automatic logic [WORD_W-1:0] mem_word(input logic [LINE_AW-1:0] la, input int ofs);
      return {la[15:0], 13'h0A5, 3'(ofs)};
   endfunction

   function automatic int exp_ofs(input int ord, input int k, input int idx);
      return (ord == 1) ? idx : (k + idx) % WORDS;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_miss(input logic [LINE_AW-1:0] la, input int k, input int ord,
                           input int rpat, input int lat, input bit holdoff);
      int q_ofs [16];
      int q_due [16];
      int qh = 0, qt = 0, req_n = 0, rsp_n = 0, cyc = 0;
      int cpu_cnt = 0, wr_after = 0, crit_pos;
      bit prev_rsp = 0, done_seen = 0, prev_stall = 0;
      int prev_ofs = 0, stall_ofs = 0;
      crit_pos = (ord == 1) ? k : 0;

      @(negedge clk);
      chk(miss_ready == 1'b1, "R9 ready before miss", miss_ready, 1);
      miss_valid     = 1'b1;
      miss_line_addr = la;
      miss_word_ofs  = OFS_W'(k);
      miss_order     = ord[0];
      @(negedge clk);
      miss_valid = holdoff;
      if (holdoff) begin
         miss_line_addr = ~la;
         miss_word_ofs  = OFS_W'(k + 3);
         miss_order     = ~ord[0];
      end

      while (!done_seen && cyc < 400) begin
         // registered outputs from the previous edge
         if (prev_rsp) begin
            chk(arr_wr_en == 1'b1, "R5 write present", arr_wr_en, 1);
            chk(arr_wr_word_ofs == OFS_W'(prev_ofs), "R5 write offset", arr_wr_word_ofs, prev_ofs);
            chk(arr_wr_data == mem_word(la, prev_ofs), "R5 write data", arr_wr_data, mem_word(la, prev_ofs));
            chk(arr_wr_line_addr == la, "R5 write line", arr_wr_line_addr, la);
            chk(cpu_rsp_valid == (prev_ofs == k), "R6 release timing", cpu_rsp_valid, prev_ofs == k);
            if (cpu_cnt > 0) wr_after++;
            if (cpu_rsp_valid) begin
               cpu_cnt++;
               chk(cpu_rsp_data == mem_word(la, k), "R6 release data", cpu_rsp_data, mem_word(la, k));
            end
            chk(fill_done == (rsp_n == WORDS), "R8 done timing", fill_done, rsp_n == WORDS);
         end else begin
            chk(arr_wr_en == 1'b0, "R5 no spurious write", arr_wr_en, 0);
            chk(fill_done == 1'b0, "R8 no spurious done", fill_done, 0);
            chk(cpu_rsp_valid == 1'b0, "R6 no spurious release", cpu_rsp_valid, 0);
         end
         if (fill_done) begin
            done_seen = 1;
            miss_valid = 1'b0;
            chk(miss_ready == 1'b1, "R9 ready at done", miss_ready, 1);
            chk(cpu_cnt == 1, "R6 single release", cpu_cnt, 1);
            chk(wr_after == WORDS - 1 - crit_pos, "R7 writes after release", wr_after, WORDS - 1 - crit_pos);
         end else begin
            chk(miss_ready == 1'b0, "R9 busy during fill", miss_ready, 0);
         end

         // request side
         mem_req_ready = (rpat == 0) ? 1'b1 : ((cyc % (rpat + 1)) != 0);
         if (prev_stall)
            chk(mem_req_valid && mem_req_word_ofs == OFS_W'(stall_ofs), "R10 stalled request held",
                mem_req_word_ofs, stall_ofs);
         prev_stall = 0;
         if (mem_req_valid) begin
            chk(req_n < WORDS, "R4 request count", req_n, WORDS - 1);
            chk(mem_req_line_addr == la, "R4 request line", mem_req_line_addr, la);
            chk(mem_req_word_ofs == OFS_W'(exp_ofs(ord, k, req_n)),
                (ord == 1) ? "R3 linear order" : "R2 wrap order",
                mem_req_word_ofs, exp_ofs(ord, k, req_n));
            if (mem_req_ready) begin
               q_ofs[qt % 16] = int'(mem_req_word_ofs);
               q_due[qt % 16] = cyc + 1 + lat;
               qt++;
               req_n++;
            end else begin
               prev_stall = 1;
               stall_ofs  = int'(mem_req_word_ofs);
            end
         end

         // response side
         if (qh != qt && q_due[qh % 16] <= cyc) begin
            mem_rsp_valid = 1'b1;
            prev_ofs      = q_ofs[qh % 16];
            mem_rsp_data  = mem_word(la, prev_ofs);
            qh++;
            rsp_n++;
            prev_rsp = 1;
         end else begin
            mem_rsp_valid = 1'b0;
            prev_rsp = 0;
         end

         @(negedge clk);
         cyc++;
      end
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      chk(done_seen, "R8 fill completes (watchdog)", done_seen, 1);
      chk(req_n == WORDS, "R4 total requests", req_n, WORDS);
      // the conflicting miss must not have started anything
      for (int i = 0; i < 3; i++) begin
         chk(mem_req_valid == 1'b0, "R9 held-off miss ignored", mem_req_valid, 0);
         chk(miss_ready == 1'b1, "R9 idle after fill", miss_ready, 1);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(miss_ready == 1'b1, "R1 reset ready", miss_ready, 1);
      chk(mem_req_valid == 1'b0, "R1 reset request", mem_req_valid, 0);
      chk(arr_wr_en == 1'b0, "R1 reset write", arr_wr_en, 0);
      chk(cpu_rsp_valid == 1'b0, "R1 reset release", cpu_rsp_valid, 0);
      chk(fill_done == 1'b0, "R1 reset done", fill_done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int ord = 0; ord < 2; ord++) begin
         for (int k = 0; k < WORDS; k++) begin
            run_miss(LINE_AW'(26'h12000 + k * 7 + ord * 64), k, ord, k % 3, (k + ord) % 4,
                     (k % 2) == ord);
         end
      end
      // back-to-back with no stalls and zero latency
      run_miss(LINE_AW'(26'h3FF00), WORDS - 1, 1, 0, 0, 1'b0);
      run_miss(LINE_AW'(26'h00001), WORDS - 1, 0, 0, 0, 1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule